// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small fully associative store of page translations placed between address generation and the page table walker. A lookup presents a 32-bit virtual address together with the access kind, user or supervisor and read or write. The block compares the virtual page number with every valid entry in the same cycle. On a match it returns the translated physical address, but the permission bits kept in the entry are checked again on every hit. A user write to a read-only entry, or any user access to a supervisor entry, raises a protection fault with no walk.

When no entry matches, the block asks for a walk. The walker's answer comes back on the fill port, and the block installs it by itself. Software never writes entries directly. A walk result that carries a fault is not installed. A write that hits an entry whose dirty bit is clear is also sent to the walker, so that the walker can set the dirty bit in memory and then refill the entry.

Entries map 4 KB pages, or 4 MB pages when the large flag is set. Reloading the table base register empties the whole buffer. A single page can also be invalidated by address.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup gives lk_hit=0 and walk_req=1.
- R2: An installed small entry hits in the cycle after its fill, with no extra delay. The lookup result comes in the same cycle as the lookup, and lk_paddr = {ppn, vaddr[11:0]}.
- R3: For every valid lookup exactly one of lk_hit, prot_fault and walk_req is 1. A lookup that misses never raises prot_fault.
- R4: A hit with lk_user=1 faults if the entry's user bit is 0. It also faults if lk_write=1 and the entry's write bit is 0. A supervisor access (lk_user=0) ignores both bits. A faulting hit gives prot_fault=1, lk_hit=0 and walk_req=0.
- R5: A permitted write that hits an entry with dirty=0 gives walk_req=1 and lk_hit=0. A read of the same entry hits. A refill for the same page replaces that entry.
- R6: An entry with the large flag matches on vaddr[31:22] only, and lk_paddr = {ppn[19:10], vaddr[21:0]}.
- R7: A cycle with base_load=1 invalidates every entry.
- R8: inv_valid removes only the entry that covers the page of inv_vaddr. If no entry covers it, nothing changes.
- R9: A fill goes to the lowest-numbered invalid entry. When all 8 entries are valid, it goes to the entry named by a round-robin pointer. The pointer is 0 after reset, advances by one only on such a replacement, and wraps from 7 to 0.
- R10: A fill is dropped if base_load or inv_valid is 1 in the same cycle, or if fill_fault=1.
- R11: An installed entry replaces every valid entry whose range overlaps it, so a lookup never matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_user | input | 1 | Access from user mode |
| lk_write | input | 1 | Access is a write |
| lk_hit | output | 1 | Translation usable this cycle |
| lk_paddr | output | 32 | Translated physical address (valid with lk_hit) |
| prot_fault | output | 1 | Hit denied by cached permissions |
| walk_req | output | 1 | Walk needed (miss or dirty update) |
| fill_valid | input | 1 | Walker result present |
| fill_vaddr | input | 32 | Virtual address that was walked |
| fill_ppn | input | 20 | Physical page number returned |
| fill_user | input | 1 | User access allowed |
| fill_write | input | 1 | Write allowed |
| fill_dirty | input | 1 | Dirty bit already set |
| fill_large | input | 1 | Entry maps a 4 MB page |
| fill_fault | input | 1 | Walker found a fault; do not install |
| base_load | input | 1 | Table base register reloaded; flush all |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vaddr | input | 32 | Address whose page is invalidated |

## Verification
Wrong internal state becomes visible at the next lookup of the affected page, one cycle after the fill, flush or invalidate that caused it. A lost entry shows as walk_req where a hit is due. A stale entry shows as a hit or a fault after a flush. Wrong permission or dirty bits show as the wrong choice among lk_hit, prot_fault and walk_req. A bad replacement pointer shows only after the buffer is full, as the wrong page missing after the ninth or tenth install. So the bench fills the buffer completely and then probes each survivor.

// File: rtl/tlb_cache.sv
`timescale 1ns/1ps
module tlb_cache #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int LARGE_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            lk_user,
  input  logic            lk_write,
  output logic            lk_hit,
  output logic [VA_W-1:0] lk_paddr,
  output logic            prot_fault,
  output logic            walk_req,
  input  logic            fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_ppn,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic            fill_user,
  input  logic            fill_write,
  input  logic            fill_dirty,
  input  logic            fill_large,
  input  logic            fill_fault,
  input  logic            base_load,
  input  logic            inv_valid,
  input  logic [VA_W-1:0] inv_vaddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int DIR_W = VA_W - LARGE_W;
  localparam int LOW_W = LARGE_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [VPN_W-1:0]   ppn_q   [ENTRIES];
  logic [ENTRIES-1:0] user_q, wr_q, dirty_q, large_q;
  logic [IDX_W-1:0]   ptr_q;

  wire [VPN_W-1:0] lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  wire [VPN_W-1:0] inv_vpn  = inv_vaddr[VA_W-1:OFF_W];
  wire [VPN_W-1:0] fill_vpn = fill_vaddr[VA_W-1:OFF_W];

  logic [ENTRIES-1:0] lk_match, inv_match, fill_ovl;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      wire top_lk   = vpn_q[g][VPN_W-1 -: DIR_W] == lk_vpn[VPN_W-1 -: DIR_W];
      wire top_inv  = vpn_q[g][VPN_W-1 -: DIR_W] == inv_vpn[VPN_W-1 -: DIR_W];
      wire top_fill = vpn_q[g][VPN_W-1 -: DIR_W] == fill_vpn[VPN_W-1 -: DIR_W];
      assign lk_match[g]  = valid_q[g] & top_lk &
                            (large_q[g] | (vpn_q[g][LOW_W-1:0] == lk_vpn[LOW_W-1:0]));
      assign inv_match[g] = valid_q[g] & top_inv &
                            (large_q[g] | (vpn_q[g][LOW_W-1:0] == inv_vpn[LOW_W-1:0]));
      assign fill_ovl[g]  = valid_q[g] & top_fill &
                            (large_q[g] | fill_large | (vpn_q[g][LOW_W-1:0] == fill_vpn[LOW_W-1:0]));
    end
  endgenerate

  logic [VPN_W-1:0] sel_ppn;
  logic sel_user, sel_wr, sel_dirty, sel_large;

  always_comb begin
    sel_ppn = '0; sel_user = 1'b0; sel_wr = 1'b0; sel_dirty = 1'b0; sel_large = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_ppn   = sel_ppn | ppn_q[i];
        sel_user  = sel_user | user_q[i];
        sel_wr    = sel_wr | wr_q[i];
        sel_dirty = sel_dirty | dirty_q[i];
        sel_large = sel_large | large_q[i];
      end
    end
  end

  wire any_match  = |lk_match;
  wire violation  = lk_user & (~sel_user | (lk_write & ~sel_wr));
  wire need_dirty = lk_write & ~sel_dirty;

  assign lk_hit     = lk_valid & any_match & ~violation & ~need_dirty;
  assign prot_fault = lk_valid & any_match & violation;
  assign walk_req   = lk_valid & (~any_match | (~violation & need_dirty));
  assign lk_paddr   = sel_large ? {sel_ppn[VPN_W-1 -: DIR_W], lk_vaddr[LARGE_W-1:0]}
                                : {sel_ppn, lk_vaddr[OFF_W-1:0]};

  logic [IDX_W-1:0] tgt, ovl_idx, free_idx;
  logic have_ovl, have_free, use_ptr;

  always_comb begin
    ovl_idx = '0; free_idx = '0; have_ovl = 1'b0; have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_ovl[i])  begin ovl_idx  = IDX_W'(i); have_ovl  = 1'b1; end
      if (!valid_q[i])  begin free_idx = IDX_W'(i); have_free = 1'b1; end
    end
    use_ptr = ~have_ovl & ~have_free;
    tgt = have_ovl ? ovl_idx : (have_free ? free_idx : ptr_q);
  end

  wire do_fill = fill_valid & ~fill_fault & ~base_load & ~inv_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (base_load) begin
      valid_q <= '0;
    end else if (inv_valid) begin
      valid_q <= valid_q & ~inv_match;
    end else if (do_fill) begin
      for (int i = 0; i < ENTRIES; i++)
        valid_q[i] <= (valid_q[i] & ~fill_ovl[i]) | (IDX_W'(i) == tgt);
      if (use_ptr)
        ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[tgt]   <= fill_vpn;
      ppn_q[tgt]   <= fill_ppn;
      user_q[tgt]  <= fill_user;
      wr_q[tgt]    <= fill_write;
      dirty_q[tgt] <= fill_dirty;
      large_q[tgt] <= fill_large;
    end
  end

  assert_one_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_match));

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, prot_fault, walk_req}) == 1);

  assert_fault_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> !walk_req && !lk_hit);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |=> valid_q == '0);

  assert_inv_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !base_load) |=> (valid_q & $past(inv_match)) == '0);

  assert_fill_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (base_load || inv_valid || fill_fault)) |=>
      $countones(valid_q) <= $countones($past(valid_q)));

  assert_fill_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_fault && !base_load && !inv_valid) |=> valid_q != '0);
endmodule

// File: tb/tlb_cache_test.sv
`timescale 1ns/1ps
module tlb_cache_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_user = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0, fill_vaddr = '0, inv_vaddr = '0;
  logic [19:0] fill_ppn = '0;
  logic fill_valid = 0, fill_user = 0, fill_write = 0, fill_dirty = 0, fill_large = 0, fill_fault = 0;
  logic base_load = 0, inv_valid = 0;
  logic lk_hit, prot_fault, walk_req;
  logic [31:0] lk_paddr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tlb_cache uut (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_user(lk_user), .lk_write(lk_write), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .prot_fault(prot_fault), .walk_req(walk_req), .fill_valid(fill_valid),
    .fill_ppn(fill_ppn), .fill_vaddr(fill_vaddr), .fill_user(fill_user),
    .fill_write(fill_write), .fill_dirty(fill_dirty), .fill_large(fill_large),
    .fill_fault(fill_fault), .base_load(base_load), .inv_valid(inv_valid),
    .inv_vaddr(inv_vaddr));

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic u, w, d, lg,
                      input logic flt = 0, input logic flush = 0, input logic inv = 0,
                      input logic [31:0] iva = 0);
    @(negedge clk);
    fill_valid = 1; fill_vaddr = va; fill_ppn = ppn; fill_user = u; fill_write = w;
    fill_dirty = d; fill_large = lg; fill_fault = flt; base_load = flush;
    inv_valid = inv; inv_vaddr = iva;
    @(negedge clk);
    fill_valid = 0; fill_fault = 0; base_load = 0; inv_valid = 0;
  endtask

  task automatic flush_all();
    @(negedge clk); base_load = 1;
    @(negedge clk); base_load = 0;
  endtask

  task automatic inv_page(input logic [31:0] va);
    @(negedge clk); inv_valid = 1; inv_vaddr = va;
    @(negedge clk); inv_valid = 0;
  endtask

  // exp: 0 = hit, 1 = walk, 2 = fault
  task automatic look(input string req, input logic [31:0] va, input logic u, w,
                      input int exp, input logic [31:0] pa = 0);
    logic [2:0] e, a;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_user = u; lk_write = w;
    #1;
    e = (exp == 0) ? 3'b100 : (exp == 1) ? 3'b010 : 3'b001;
    a = {lk_hit, walk_req, prot_fault};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s va=%h hit/walk/fault actual=%b expected=%b", req, va, a, e);
    end else if (exp == 0 && lk_paddr !== pa) begin
      errors++;
      $display("FAIL %s va=%h paddr actual=%h expected=%h", req, va, lk_paddr, pa);
    end
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic t_reset();
    look("R1", 32'h0040_2000, 1, 0, 1);
    look("R3", 32'h0000_0000, 0, 1, 1);
  endtask

  task automatic t_basic();
    fill(32'h0040_2000, 20'h00003, 1, 1, 1, 0);
    look("R2", 32'h0040_2abc, 1, 0, 0, 32'h0000_3abc);
    look("R2", 32'h0040_3000, 1, 0, 1);
  endtask

  task automatic t_protect();
    fill(32'h1000_0000, 20'h11111, 1, 0, 1, 0);
    look("R4", 32'h1000_0004, 1, 1, 2);
    look("R4", 32'h1000_0004, 1, 0, 0, 32'h1111_1004);
    look("R4", 32'h1000_0008, 0, 1, 0, 32'h1111_1008);
    fill(32'h2000_0000, 20'h22222, 0, 1, 1, 0);
    look("R4", 32'h2000_0010, 1, 0, 2);
    look("R4", 32'h2000_0010, 0, 0, 0, 32'h2222_2010);
  endtask

  task automatic t_dirty();
    fill(32'h3000_0000, 20'h33333, 1, 1, 0, 0);
    look("R5", 32'h3000_0020, 1, 0, 0, 32'h3333_3020);
    look("R5", 32'h3000_0020, 1, 1, 1);
    fill(32'h3000_0000, 20'h33333, 1, 1, 1, 0);
    look("R5", 32'h3000_0024, 1, 1, 0, 32'h3333_3024);
  endtask

  task automatic t_large();
    fill(32'h4000_0000, 20'h80000, 1, 1, 1, 1);
    look("R6", 32'h403f_f123, 1, 0, 0, 32'h803f_f123);
    look("R6", 32'h4040_0000, 1, 0, 1);
  endtask

  task automatic t_flush();
    flush_all();
    look("R7", 32'h0040_2000, 1, 0, 1);
    look("R7", 32'h1000_0000, 0, 0, 1);
    look("R7", 32'h4000_0000, 1, 0, 1);
  endtask

  task automatic t_inv();
    fill(32'h0700_1000, 20'h00071, 1, 1, 1, 0);
    fill(32'h0700_2000, 20'h00072, 1, 1, 1, 0);
    inv_page(32'h0700_1fff);
    look("R8", 32'h0700_1000, 1, 0, 1);
    look("R8", 32'h0700_2004, 1, 0, 0, 32'h0007_2004);
    inv_page(32'h0700_9000);
    look("R8", 32'h0700_2008, 1, 0, 0, 32'h0007_2008);
  endtask

  task automatic t_priority();
    fill(32'h0800_0000, 20'h00080, 1, 1, 1, 0, 0, 1, 0);
    look("R10", 32'h0800_0000, 1, 0, 1);
    fill(32'h0800_0000, 20'h00080, 1, 1, 1, 0, 0, 0, 1, 32'h0900_0000);
    look("R10", 32'h0800_0000, 1, 0, 1);
    fill(32'h0800_0000, 20'h00080, 1, 1, 1, 0, 1);
    look("R10", 32'h0800_0000, 1, 0, 1);
  endtask

  task automatic t_overlap();
    fill(32'h5000_1000, 20'h00051, 1, 1, 1, 0);
    fill(32'h5000_2000, 20'h00052, 1, 1, 1, 0);
    fill(32'h5000_0000, 20'h90000, 1, 1, 1, 1);
    look("R11", 32'h5000_1abc, 1, 0, 0, 32'h9000_1abc);
    inv_page(32'h5000_1000);
    look("R11", 32'h5000_2000, 1, 0, 1);
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 8; i++)
      fill(32'h6000_0000 + (i << 12), 20'h00060 + i, 1, 1, 1, 0);
    for (int i = 0; i < 8; i++)
      look("R9", 32'h6000_0000 + (i << 12), 1, 0, 0, (32'h60 + i) << 12);
    fill(32'h6000_8000, 20'h00068, 1, 1, 1, 0);
    look("R9", 32'h6000_0000, 1, 0, 1);
    look("R9", 32'h6000_1000, 1, 0, 0, 32'h0006_1000);
    look("R9", 32'h6000_8000, 1, 0, 0, 32'h0006_8000);
    fill(32'h6000_9000, 20'h00069, 1, 1, 1, 0);
    look("R9", 32'h6000_1000, 1, 0, 1);
    inv_page(32'h6000_4000);
    fill(32'h6000_a000, 20'h0006a, 1, 1, 1, 0);
    look("R9", 32'h6000_2000, 1, 0, 0, 32'h0006_2000);
    look("R9", 32'h6000_a000, 1, 0, 0, 32'h0006_a000);
    fill(32'h6000_b000, 20'h0006b, 1, 1, 1, 0);
    look("R9", 32'h6000_2000, 1, 0, 1);
    look("R9", 32'h6000_3000, 1, 0, 0, 32'h0006_3000);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_protect();
    t_dirty();
    t_large();
    t_flush();
    t_inv();
    t_priority();
    t_overlap();
    t_replace();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule